// File: doc/BRIEF.md
# GPIO and Control Register Block

This block is a small bank of 16-bit registers on a simple synchronous memory-mapped bus. It holds mode, card-detect, card-control, power and three interrupt-related words as plain storage. It also holds a GPIO direction word and a GPIO level word, and it drives a GPIO output vector from them. Software writes a register by presenting an offset, a write strobe and data. It reads a register by presenting an offset and a read strobe, and the data comes back on the following cycle.

The GPIO outputs show the stored level gated by the direction word. The outputs are refreshed only when the bus writes the direction or the level. On each refresh, a one-cycle change vector marks every output bit whose gated value differs from the value driven before. External input strobes can set or clear individual level bits at any time. They do not mask against direction and do not refresh the outputs by themselves.

The bus has no back-pressure. Every strobe is accepted in the cycle it is presented. Read data is held until the next read strobe.

Top module: `pcr_top`

## Requirements
- R1: After reset, every readable register returns 0x0000 except the status register at offset 0x08, which returns 0x0002. `gpio_out` and `gpio_chg` are 0.
- R2: A read strobe with a decoded offset loads that register into `bus_rdata` at the clock edge, so the value is visible one cycle later. If a write and a read hit the same offset in one cycle, the read returns the value from before the write. `bus_rdata` holds its value while no read strobe is present.
- R3: The plain registers at offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C store only bits 15:0 of the 32-bit write data and return those bits on a read.
- R4: A write to the power register at 0x0C stores the low 16 bits. When bit 7 of the written value is 1, bits 15 and 6 are also set (OR with 0x8040).
- R5: The status register at 0x08 cannot be written. Writes to 0x08 leave it reading 0x0002.
- R6: A write to 0x24 or to 0x28 stores (write data AND current direction) as the GPIO level. Reads of 0x24 and 0x28 both return the level. A read of 0x20 returns the direction, and a write to 0x20 stores the direction.
- R7: On each bus write to 0x20, 0x24 or 0x28, `gpio_out` becomes (new level AND new direction) at that edge. For that one cycle, `gpio_chg` shows the bits that differ from the previous `gpio_out`. In all other cycles `gpio_out` holds and `gpio_chg` is 0.
- R8: When a bit of `pin_evt` is 1, that level bit takes the value of the same bit of `pin_val`, whatever the direction. This does not change `gpio_out` or `gpio_chg`.
- R9: When a bus write to the level offset and input strobes fall in the same cycle, the bus write decides the whole level word.
- R10: Only address bits 5:0 are decoded. An address with other upper bits reaches the same register.
- R11: Offsets that are not word-aligned, and aligned offsets from 0x2C to 0x3C, are undecoded. A read of one returns 0. A write to one changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 5:0 decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WDATA_W | Write data; bits 15:0 used |
| bus_rdata | output | 16 | Registered read data |
| pin_evt | input | GPIO_N | Per-bit input strobe |
| pin_val | input | GPIO_N | Value applied to each strobed level bit |
| gpio_out | output | GPIO_N | Driven outputs: level AND direction |
| gpio_chg | output | GPIO_N | One-cycle mark of toggled output bits |

## Verification
The GPIO path is driven with level writes through both level offsets under a partial direction mask. This separates masking by the direction word from plain storage. A direction change with the level left untouched shows that the outputs and change marks are taken from the gated value and not from the raw level. Input strobes that set and clear bits are followed by a read and then by a refresh. This tells a level that changes silently apart from outputs that would follow the inputs at once, and a same-cycle strobe-plus-write case exposes the priority order. Aliased, misaligned and out-of-map addresses, together with a simultaneous read and write, test the decode and the read timing.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int SLOT_N   = 11;
  localparam int IDX_W    = 4;
  localparam int PLAIN_N  = 8;
  localparam int DW       = 16;

  typedef enum logic [IDX_W-1:0] {
    S_MODE = 4'd0, S_CDET = 4'd1, S_STAT = 4'd2, S_PWR  = 4'd3,
    S_CCTL = 4'd4, S_IRQR = 4'd5, S_IRQM = 4'd6, S_IRQS = 4'd7,
    S_DIR  = 4'd8, S_LVL  = 4'd9, S_LVLR = 4'd10
  } slot_e;

  localparam logic [DW-1:0] STAT_RST   = 16'h0002;
  localparam int            PWR_TRIG   = 7;
  localparam logic [DW-1:0] PWR_FORCE  = 16'h8040;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [5:0] off;
  assign off = addr[5:0];
  assign idx = off[5:2];
  assign hit = (off[1:0] == 2'b00) && (int'(off[5:2]) < SLOT_N);
endmodule

// File: rtl/pcr_store.sv
module pcr_store
  import pcr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DW-1:0]           wdata,
  output logic [PLAIN_N-1:0][DW-1:0] val
);
  for (genvar i = 0; i < PLAIN_N; i++) begin : g_slot
    if (i == int'(S_STAT)) begin : g_ro
      assign val[i] = STAT_RST;
    end else if (i == int'(S_PWR)) begin : g_pwr
      always_ff @(posedge clk) begin
        if (!rst_n)
          val[i] <= '0;
        else if (we && idx == IDX_W'(i))
          val[i] <= wdata[PWR_TRIG] ? (wdata | PWR_FORCE) : wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)
          val[i] <= '0;
        else if (we && idx == IDX_W'(i))
          val[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/pcr_gpio.sv
module pcr_gpio #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] evt_val,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] out_q,
  output logic [N-1:0] chg_q
);
  logic [N-1:0] lvl_ev, lvl_nx, dir_nx, gated;
  logic         upd;

  always_comb begin
    lvl_ev = (lvl_q & ~evt) | (evt_val & evt);
    lvl_nx = lvl_we ? (wdata & dir_q) : lvl_ev;
    dir_nx = dir_we ? wdata : dir_q;
    gated  = lvl_nx & dir_nx;
    upd    = dir_we | lvl_we;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      out_q <= '0;
      chg_q <= '0;
    end else begin
      dir_q <= dir_nx;
      lvl_q <= lvl_nx;
      if (upd) out_q <= gated;
      chg_q <= upd ? (gated ^ out_q) : '0;
    end
  end
endmodule

// File: rtl/pcr_top.sv
module pcr_top
  import pcr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WDATA_W = 32,
  parameter int GPIO_N  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [WDATA_W-1:0] bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [GPIO_N-1:0]  pin_evt,
  input  logic [GPIO_N-1:0]  pin_val,
  output logic [GPIO_N-1:0]  gpio_out,
  output logic [GPIO_N-1:0]  gpio_chg
);
  logic                       hit, we;
  logic [IDX_W-1:0]           idx;
  logic [DW-1:0]              wd16, rd_mux, dir16, lvl16, pwr_q;
  logic [PLAIN_N-1:0][DW-1:0] plain;
  logic [GPIO_N-1:0]          gpio_dir, gpio_lvl;
  logic                       dir_we, lvl_we;

  assign wd16   = bus_wdata[DW-1:0];
  assign we     = bus_wr && hit;
  assign dir_we = we && idx == S_DIR;
  assign lvl_we = we && (idx == S_LVL || idx == S_LVLR);
  assign pwr_q  = plain[S_PWR];

  pcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  pcr_store u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .idx(idx), .wdata(wd16), .val(plain)
  );

  pcr_gpio #(.N(GPIO_N)) u_gpio (
    .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .lvl_we(lvl_we),
    .wdata(wd16[GPIO_N-1:0]), .evt(pin_evt), .evt_val(pin_val),
    .dir_q(gpio_dir), .lvl_q(gpio_lvl), .out_q(gpio_out), .chg_q(gpio_chg)
  );

  always_comb begin
    dir16 = '0;
    lvl16 = '0;
    dir16[GPIO_N-1:0] = gpio_dir;
    lvl16[GPIO_N-1:0] = gpio_lvl;
    if (!hit)
      rd_mux = '0;
    else if (idx == S_DIR)
      rd_mux = dir16;
    else if (idx == S_LVL || idx == S_LVLR)
      rd_mux = lvl16;
    else
      rd_mux = plain[idx[2:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pcr_chk.sv
module pcr_chk #(
  parameter int ADDR_W  = 12,
  parameter int WDATA_W = 32,
  parameter int GPIO_N  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [WDATA_W-1:0] bus_wdata,
  input logic [15:0]        bus_rdata,
  input logic [GPIO_N-1:0]  gpio_out,
  input logic [GPIO_N-1:0]  gpio_chg,
  input logic [GPIO_N-1:0]  gpio_dir,
  input logic [GPIO_N-1:0]  gpio_lvl,
  input logic [15:0]        pwr_q
);
  logic [5:0] off;
  logic       gp_wr, lv_wr, undec;
  assign off   = bus_addr[5:0];
  assign lv_wr = bus_wr && (off == 6'h24 || off == 6'h28);
  assign gp_wr = lv_wr || (bus_wr && off == 6'h20);
  assign undec = (off[1:0] != 2'b00) || (off > 6'h28);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gp_wr |=> $stable(gpio_out));
  assert_chg_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_chg == (gpio_out ^ $past(gpio_out)));
  assert_out_in_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_out & ~gpio_dir) == '0);
  assert_lvl_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lv_wr |=> (gpio_lvl & ~$past(gpio_dir)) == '0);
  assert_pwr_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == 6'h0C && bus_wdata[7]) |=> (pwr_q[15] && pwr_q[6]));
  assert_undec_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && undec) |=> bus_rdata == 16'h0000);
  assert_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && off == 6'h08) |=> bus_rdata == 16'h0002);
endmodule

bind pcr_top pcr_chk #(.ADDR_W(ADDR_W), .WDATA_W(WDATA_W), .GPIO_N(GPIO_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .gpio_out(gpio_out), .gpio_chg(gpio_chg), .gpio_dir(gpio_dir),
  .gpio_lvl(gpio_lvl), .pwr_q(pwr_q)
);

// File: tb/tb_pcr_top.sv
module tb_pcr_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_evt = '0, pin_val = '0;
  logic [15:0] gpio_out, gpio_chg;

  int total = 0, bad = 0;
  int    exp_q[$];
  string tag_q[$];
  logic  pend = 0;

  always #10 clk = ~clk;

  pcr_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_evt(pin_evt), .pin_val(pin_val), .gpio_out(gpio_out), .gpio_chg(gpio_chg)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each read strobe
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'(bus_rdata), e);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, int exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic outs(int eo, int ec, string tag);
    chk({tag, " out"}, int'(gpio_out), eo);
    chk({tag, " chg"}, int'(gpio_chg), ec);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    outs(0, 0, "R1");
    for (int i = 0; i <= 10; i++)
      rd(12'(i * 4), (i == 2) ? 16'h0002 : 0, "R1 reset read");
    // R3 truncation on plain slots
    wr(12'h000, 32'h1234_5ABC); rd(12'h000, 16'h5ABC, "R3 mode");
    wr(12'h004, 32'hFFFF_00A5); rd(12'h004, 16'h00A5, "R3 cdet");
    wr(12'h010, 32'h0001_7E7E); rd(12'h010, 16'h7E7E, "R3 cctl");
    wr(12'h014, 32'h0000_1357); rd(12'h014, 16'h1357, "R3 irq req");
    wr(12'h018, 32'h0000_2468); rd(12'h018, 16'h2468, "R3 irq mask");
    wr(12'h01C, 32'h0000_ABCD); rd(12'h01C, 16'hABCD, "R3 irq stat");
    // R4 power side effect
    wr(12'h00C, 32'h0000_0080); rd(12'h00C, 16'h80C0, "R4 power bit7");
    wr(12'h00C, 32'h0000_0001); rd(12'h00C, 16'h0001, "R4 power plain");
    // R5 status read-only
    wr(12'h008, 32'h0000_FFFF); rd(12'h008, 16'h0002, "R5 status");
    // R6 / R7 gpio
    wr(12'h020, 32'h0000_00FF); outs(0, 0, "R7 dir no level");
    wr(12'h024, 32'h0000_0F0F); outs(16'h000F, 16'h000F, "R7 level write");
    @(negedge clk); outs(16'h000F, 0, "R7 pulse ends");
    rd(12'h024, 16'h000F, "R6 level via 0x24");
    rd(12'h028, 16'h000F, "R6 level via 0x28");
    rd(12'h020, 16'h00FF, "R6 dir read");
    wr(12'h020, 32'h0000_0F03); outs(16'h0003, 16'h000C, "R7 dir change");
    rd(12'h024, 16'h000F, "R6 level kept");
    wr(12'h028, 32'h0000_FFFF); outs(16'h0F03, 16'h0F00, "R6 write via 0x28");
    // R8 input strobes
    pin_evt = 16'h8001; pin_val = 16'h8000;
    @(negedge clk); pin_evt = 0; pin_val = 0;
    outs(16'h0F03, 0, "R8 no refresh");
    rd(12'h028, 16'h8F02, "R8 level");
    wr(12'h020, 32'h0000_0F03); outs(16'h0F02, 16'h0001, "R8 later refresh");
    // R9 priority
    pin_evt = 16'h4000; pin_val = 16'h4000;
    bus_addr = 12'h024; bus_wdata = 0; bus_wr = 1;
    @(negedge clk); bus_wr = 0; pin_evt = 0; pin_val = 0;
    outs(0, 16'h0F02, "R9 same cycle");
    rd(12'h024, 0, "R9 level");
    // R10 aliasing
    wr(12'h040, 32'h0000_1111); rd(12'h000, 16'h1111, "R10 alias write");
    rd(12'hFC0, 16'h1111, "R10 alias read");
    rd(12'h860, 16'h0F03, "R10 alias dir");
    // R11 undecoded
    wr(12'h02C, 32'h0000_FFFF); wr(12'h001, 32'h0000_FFFF); wr(12'h022, 32'h0000_FFFF);
    outs(0, 0, "R11 outputs");
    rd(12'h02C, 0, "R11 read 0x2C");
    rd(12'h03C, 0, "R11 read 0x3C");
    rd(12'h001, 0, "R11 misaligned");
    rd(12'h000, 16'h1111, "R11 mode kept");
    rd(12'h020, 16'h0F03, "R11 dir kept");
    // R2 read/write same cycle, then hold
    exp_q.push_back(16'h1111); tag_q.push_back("R2 read before write");
    bus_addr = 12'h000; bus_wdata = 32'h2222; bus_wr = 1; bus_rd = 1;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    @(negedge clk); chk("R2 hold", int'(bus_rdata), 16'h1111);
    rd(12'h000, 16'h2222, "R2 new value");
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule